// File: doc/BRIEF.md
# Thread Block Dispatcher

This block takes kernel launch requests one at a time and places each of the launch's thread blocks on one of a set of multiprocessor slots. A request carries the number of blocks, the threads in each block, and what one block needs in registers and shared memory. For every slot the dispatcher keeps the count of resident blocks and how many registers and how much shared memory they use. It gives the next block to the first slot that can still hold it, scanning round-robin from the slot after the one used last. A block stays on its slot until that slot reports that a block has finished, and then its resources are returned.

A launch is checked when it is accepted. If the thread count is above the limit for the selected mode, or one block needs more than an empty slot owns, the launch is refused with an error pulse and none of its blocks is placed. When every block of an accepted launch has been placed and has finished, a done pulse marks the end of the launch and the next request can be accepted.

Top module: `block_dispatcher`

## Requirements
- R1: A slot never holds more than MAX_RES (default 8) resident blocks, even when its registers and shared memory would allow more; extra blocks wait until a block on some slot finishes.
- R2: The registers and shared memory used by the blocks on a slot never exceed REG_TOTAL and SMEM_TOTAL; a block is placed only on a slot where both sums still fit, so residency can be limited by either resource.
- R3: With ext_mode low a launch with more than 512 threads per block is refused, with ext_mode high one with more than 1024; refusal is a one-cycle launch_err pulse in the cycle after acceptance, no block of the launch is placed and launch_ready stays high.
- R4: A launch whose per-block register or shared memory need exceeds REG_TOTAL or SMEM_TOTAL is refused in the same way as in R3.
- R5: Blocks are issued with asg_block counting 0, 1, 2, ... and each goes wholly to one slot; the slot is the first that fits when scanning upward (wrapping) from the slot after the one last assigned; after reset the scan starts at slot 0, and the pointer carries over between launches.
- R6: While asg_valid is high and asg_ready is low, asg_valid stays high and asg_block and asg_sm do not change.
- R7: A cmp_valid pulse naming a slot frees one block's registers and shared memory on that slot, letting a waiting block be placed there; a pulse naming a slot with no resident block is ignored and counts toward nothing.
- R8: launch_done pulses for one cycle after the last block of a launch has finished and all resources are back; it never pulses while a block of the launch is unfinished; a launch of zero blocks pulses launch_done in the cycle after acceptance without any assignment.
- R9: launch_ready is high only between launches; a request presented while a launch is in progress is not taken.
- R10: After reset launch_ready is high, asg_valid, launch_err and launch_done are low and all slots are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Selects the 1024-thread limit instead of 512 |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Dispatcher idle, request taken this cycle |
| launch_blocks | input | BLK_W | Number of blocks in the launch |
| launch_threads | input | THR_W | Threads per block |
| launch_regs | input | clog2(REG_TOTAL+1) | Registers one block needs |
| launch_smem | input | clog2(SMEM_TOTAL+1) | Shared memory one block needs |
| asg_valid | output | 1 | Block assignment offered |
| asg_ready | input | 1 | Consumer takes the assignment |
| asg_block | output | BLK_W | Index of the block within its launch |
| asg_sm | output | clog2(NUM_SM) | Slot the block is placed on |
| cmp_valid | input | 1 | A block on slot cmp_sm has finished |
| cmp_sm | input | clog2(NUM_SM) | Slot reporting completion |
| launch_err | output | 1 | Launch refused (pulse) |
| launch_done | output | 1 | All blocks of the launch finished (pulse) |

## Verification
The bench runs a four-slot configuration and mirrors slot occupancy in its own arithmetic, so every offered assignment is compared with the slot the round-robin rule predicts. A launch of many tiny blocks fills every slot to the block cap, telling the count limit apart from the resource limits; launches with large register or shared memory needs stall earlier and show which resource bounds residency. Thread counts just over each mode's limit and per-block needs just over a slot's capacity separate refusal from admission, while zero-block launches, held-off assignments and completions aimed at empty slots probe the done pulse, the handshake and the ignore rule.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bd_state_e;
endpackage

// File: rtl/bd_admit.sv
// Launch admission: thread limit per mode and per-block resource limits.
module bd_admit #(
  parameter int THR_W      = 11,
  parameter int REG_W      = 16,
  parameter int SMEM_W     = 16,
  parameter int BASE_THR   = 512,
  parameter int EXT_THR    = 1024,
  parameter int REG_TOTAL  = 32768,
  parameter int SMEM_TOTAL = 49152
) (
  input  logic              ext_mode,
  input  logic [THR_W-1:0]  threads,
  input  logic [REG_W-1:0]  regs,
  input  logic [SMEM_W-1:0] smem,
  output logic              ok
);
  localparam int CAP_W = THR_W + 1;

  logic [CAP_W-1:0] thr_cap;
  logic             thr_ok;
  logic             res_ok;

  always_comb begin
    thr_cap = ext_mode ? CAP_W'(EXT_THR) : CAP_W'(BASE_THR);
    thr_ok  = {1'b0, threads} <= thr_cap;
    res_ok  = ({1'b0, regs} <= (REG_W+1)'(REG_TOTAL)) &&
              ({1'b0, smem} <= (SMEM_W+1)'(SMEM_TOTAL));
    ok      = thr_ok && res_ok;
  end
endmodule

// File: rtl/bd_rr_pick.sv
// Round-robin choice of the first fitting slot after the last one used.
module bd_rr_pick #(
  parameter int NUM_SM = 30,
  parameter int SM_W   = 5
) (
  input  logic [NUM_SM-1:0] fit,
  input  logic [SM_W-1:0]   last,
  output logic              any,
  output logic [SM_W-1:0]   pick
);
  int idx;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    idx  = 0;
    for (int j = 0; j < NUM_SM; j++) begin
      idx = (int'(last) + 1 + j) % NUM_SM;
      if (!any && fit[idx]) begin
        any  = 1'b1;
        pick = SM_W'(idx);
      end
    end
  end
endmodule

// File: rtl/bd_sm_table.sv
// Per-slot occupancy: resident block count plus register and shared memory use.
module bd_sm_table #(
  parameter int NUM_SM     = 30,
  parameter int MAX_RES    = 8,
  parameter int REG_TOTAL  = 32768,
  parameter int SMEM_TOTAL = 49152,
  parameter int SM_W       = 5,
  parameter int REG_W      = 16,
  parameter int SMEM_W     = 16,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  need_regs,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic              rsv_en,
  input  logic [SM_W-1:0]   rsv_sm,
  input  logic              rel_en,
  input  logic [SM_W-1:0]   rel_sm,
  output logic [NUM_SM-1:0] fit,
  output logic [NUM_SM-1:0] busy
);
  for (genvar g = 0; g < NUM_SM; g++) begin : g_slot
    logic [CNT_W-1:0]  cnt;
    logic [REG_W-1:0]  reg_used;
    logic [SMEM_W-1:0] smem_used;
    logic [REG_W:0]    reg_sum;
    logic [SMEM_W:0]   smem_sum;
    logic              inc;
    logic              dec;

    assign inc      = rsv_en && (rsv_sm == SM_W'(g));
    assign dec      = rel_en && (rel_sm == SM_W'(g));
    assign reg_sum  = {1'b0, reg_used} + {1'b0, need_regs};
    assign smem_sum = {1'b0, smem_used} + {1'b0, need_smem};
    assign fit[g]   = (cnt < CNT_W'(MAX_RES)) &&
                      (reg_sum <= (REG_W+1)'(REG_TOTAL)) &&
                      (smem_sum <= (SMEM_W+1)'(SMEM_TOTAL));
    assign busy[g]  = (cnt != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt       <= '0;
        reg_used  <= '0;
        smem_used <= '0;
      end else begin
        case ({inc, dec})
          2'b10: begin
            cnt       <= cnt + 1'b1;
            reg_used  <= reg_used + need_regs;
            smem_used <= smem_used + need_smem;
          end
          2'b01: begin
            cnt       <= cnt - 1'b1;
            reg_used  <= reg_used - need_regs;
            smem_used <= smem_used - need_smem;
          end
          default: ;
        endcase
      end
    end

    AST_SLOT_CAP: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(MAX_RES)); // R1
    AST_SLOT_RES: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, reg_used} <= (REG_W+1)'(REG_TOTAL)) &&
      ({1'b0, smem_used} <= (SMEM_W+1)'(SMEM_TOTAL))); // R2
    AST_RSV_FITS: assert property (@(posedge clk) disable iff (rst)
      inc |-> fit[g]); // R2
    AST_REL_OCC: assert property (@(posedge clk) disable iff (rst)
      dec |-> busy[g]); // R7
  end
endmodule

// File: rtl/block_dispatcher.sv
// Places whole thread blocks of one launch at a time onto multiprocessor slots.
module block_dispatcher #(
  parameter int NUM_SM     = 30,
  parameter int MAX_RES    = 8,
  parameter int REG_TOTAL  = 32768,
  parameter int SMEM_TOTAL = 49152,
  parameter int BLK_W      = 16,
  parameter int THR_W      = 11,
  parameter int BASE_THR   = 512,
  parameter int EXT_THR    = 1024,
  localparam int SM_W      = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int REG_W     = $clog2(REG_TOTAL + 1),
  localparam int SMEM_W    = $clog2(SMEM_TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [BLK_W-1:0]  launch_blocks,
  input  logic [THR_W-1:0]  launch_threads,
  input  logic [REG_W-1:0]  launch_regs,
  input  logic [SMEM_W-1:0] launch_smem,
  output logic              asg_valid,
  input  logic              asg_ready,
  output logic [BLK_W-1:0]  asg_block,
  output logic [SM_W-1:0]   asg_sm,
  input  logic              cmp_valid,
  input  logic [SM_W-1:0]   cmp_sm,
  output logic              launch_err,
  output logic              launch_done
);
  import bd_pkg::*;

  localparam int CNT_W = $clog2(MAX_RES + 1);
  localparam int INF_W = $clog2(NUM_SM * MAX_RES + 1);

  bd_state_e         state_q;
  logic              asg_valid_q;
  logic [BLK_W-1:0]  asg_blk_q;
  logic [SM_W-1:0]   asg_sm_q;
  logic [BLK_W-1:0]  rem_q;
  logic [BLK_W-1:0]  nidx_q;
  logic [REG_W-1:0]  need_regs_q;
  logic [SMEM_W-1:0] need_smem_q;
  logic [SM_W-1:0]   last_q;
  logic [INF_W-1:0]  inflight_q;
  logic              err_q;
  logic              done_q;

  logic              adm_ok;
  logic [NUM_SM-1:0] fit;
  logic [NUM_SM-1:0] busy;
  logic              any_fit;
  logic [SM_W-1:0]   pick;
  logic              load;
  logic              rel_ok;

  bd_admit #(
    .THR_W(THR_W), .REG_W(REG_W), .SMEM_W(SMEM_W),
    .BASE_THR(BASE_THR), .EXT_THR(EXT_THR),
    .REG_TOTAL(REG_TOTAL), .SMEM_TOTAL(SMEM_TOTAL)
  ) u_admit (
    .ext_mode(ext_mode),
    .threads (launch_threads),
    .regs    (launch_regs),
    .smem    (launch_smem),
    .ok      (adm_ok)
  );

  bd_sm_table #(
    .NUM_SM(NUM_SM), .MAX_RES(MAX_RES),
    .REG_TOTAL(REG_TOTAL), .SMEM_TOTAL(SMEM_TOTAL),
    .SM_W(SM_W), .REG_W(REG_W), .SMEM_W(SMEM_W), .CNT_W(CNT_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .need_regs(need_regs_q),
    .need_smem(need_smem_q),
    .rsv_en   (load),
    .rsv_sm   (pick),
    .rel_en   (rel_ok),
    .rel_sm   (cmp_sm),
    .fit      (fit),
    .busy     (busy)
  );

  bd_rr_pick #(
    .NUM_SM(NUM_SM), .SM_W(SM_W)
  ) u_pick (
    .fit (fit),
    .last(last_q),
    .any (any_fit),
    .pick(pick)
  );

  // A completion counts only if it names an existing slot that holds a block.
  always_comb begin
    rel_ok = 1'b0;
    for (int i = 0; i < NUM_SM; i++) begin
      if (cmp_valid && (cmp_sm == SM_W'(i)) && busy[i]) rel_ok = 1'b1;
    end
  end

  assign load = (state_q == ST_RUN) && (!asg_valid_q || asg_ready) &&
                (rem_q != '0) && any_fit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      asg_valid_q <= 1'b0;
      asg_blk_q   <= '0;
      asg_sm_q    <= '0;
      rem_q       <= '0;
      nidx_q      <= '0;
      need_regs_q <= '0;
      need_smem_q <= '0;
      last_q      <= SM_W'(NUM_SM - 1);
      inflight_q  <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case ({load, rel_ok})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: ;
      endcase
      case (state_q)
        ST_IDLE: begin
          if (launch_valid) begin
            if (!adm_ok) begin
              err_q <= 1'b1;
            end else if (launch_blocks == '0) begin
              done_q <= 1'b1;
            end else begin
              rem_q       <= launch_blocks;
              nidx_q      <= '0;
              need_regs_q <= launch_regs;
              need_smem_q <= launch_smem;
              state_q     <= ST_RUN;
            end
          end
        end
        default: begin
          if (load) begin
            asg_valid_q <= 1'b1;
            asg_sm_q    <= pick;
            asg_blk_q   <= nidx_q;
            nidx_q      <= nidx_q + 1'b1;
            rem_q       <= rem_q - 1'b1;
            last_q      <= pick;
          end else if (asg_ready) begin
            asg_valid_q <= 1'b0;
          end
          if ((rem_q == '0) && !asg_valid_q && (inflight_q == '0)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign launch_ready = (state_q == ST_IDLE);
  assign asg_valid    = asg_valid_q;
  assign asg_block    = asg_blk_q;
  assign asg_sm       = asg_sm_q;
  assign launch_err   = err_q;
  assign launch_done  = done_q;

  AST_ASG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (asg_valid && !asg_ready) |=> (asg_valid && $stable(asg_sm) && $stable(asg_block))); // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch_err |-> (launch_ready && !asg_valid)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    launch_ready |-> !asg_valid); // R9
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    launch_done |-> ((inflight_q == '0) && !asg_valid && !launch_err)); // R8
endmodule

// File: tb/block_dispatcher_bench.sv
module block_dispatcher_bench;
  localparam int NSM   = 4;
  localparam int MRES  = 8;
  localparam int RTOT  = 64;
  localparam int STOT  = 64;
  localparam int BW    = 8;
  localparam int TW    = 11;
  localparam int SW    = 2;
  localparam int RW    = 7;
  localparam int MW    = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_mode = 1'b0;
  logic          launch_valid = 1'b0;
  logic          launch_ready;
  logic [BW-1:0] launch_blocks = '0;
  logic [TW-1:0] launch_threads = '0;
  logic [RW-1:0] launch_regs = '0;
  logic [MW-1:0] launch_smem = '0;
  logic          asg_valid;
  logic          asg_ready = 1'b1;
  logic [BW-1:0] asg_block;
  logic [SW-1:0] asg_sm;
  logic          cmp_valid = 1'b0;
  logic [SW-1:0] cmp_sm = '0;
  logic          launch_err;
  logic          launch_done;

  block_dispatcher #(
    .NUM_SM(NSM), .MAX_RES(MRES), .REG_TOTAL(RTOT), .SMEM_TOTAL(STOT),
    .BLK_W(BW), .THR_W(TW)
  ) u_block_dispatcher (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_regs(launch_regs), .launch_smem(launch_smem),
    .asg_valid(asg_valid), .asg_ready(asg_ready),
    .asg_block(asg_block), .asg_sm(asg_sm),
    .cmp_valid(cmp_valid), .cmp_sm(cmp_sm),
    .launch_err(launch_err), .launch_done(launch_done)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench model of slot occupancy
  int m_cnt [NSM];
  int m_regs[NSM];
  int m_smem[NSM];
  int m_last = NSM - 1;
  int cur_regs = 0;
  int cur_smem = 0;
  int cur_blocks = 0;
  int exp_blk = 0;
  int asg_cnt = 0;
  int err_cnt = 0;
  int done_cnt = 0;
  bit pend_rel = 1'b0;
  int pend_sm = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_pick();
    int idx;
    for (int j = 0; j < NSM; j++) begin
      idx = (m_last + 1 + j) % NSM;
      if (m_cnt[idx] < MRES && m_regs[idx] + cur_regs <= RTOT &&
          m_smem[idx] + cur_smem <= STOT) return idx;
    end
    return -1;
  endfunction

  function automatic int model_total();
    int t = 0;
    for (int i = 0; i < NSM; i++) t += m_cnt[i];
    return t;
  endfunction

  // Monitor: samples after the bench has driven inputs for the next edge.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      int e;
      if (launch_err) err_cnt++;
      if (launch_done) done_cnt++;
      if (asg_valid && asg_ready) begin
        e = model_pick();
        chk(e >= 0 && int'(asg_sm) == e, "R5", "assigned slot", int'(asg_sm), e);
        chk(int'(asg_block) == exp_blk, "R5", "block index", int'(asg_block), exp_blk);
        if (e >= 0) begin
          m_cnt[e]++;
          m_regs[e] += cur_regs;
          m_smem[e] += cur_smem;
          m_last = e;
        end
        exp_blk++;
        asg_cnt++;
      end
      if (pend_rel && m_cnt[pend_sm] > 0) begin
        m_cnt[pend_sm]--;
        m_regs[pend_sm] -= cur_regs;
        m_smem[pend_sm] -= cur_smem;
      end
      pend_rel = cmp_valid;
      pend_sm  = int'(cmp_sm);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic launch(input int b, input int t, input int r, input int s, input bit ext);
    step(1);
    ext_mode       = ext;
    launch_blocks  = BW'(b);
    launch_threads = TW'(t);
    launch_regs    = RW'(r);
    launch_smem    = MW'(s);
    launch_valid   = 1'b1;
    if (launch_ready) begin
      cur_regs = r; cur_smem = s; cur_blocks = b; exp_blk = 0;
    end
    step(1);
    launch_valid = 1'b0;
  endtask

  task automatic complete(input int sm);
    cmp_sm    = SW'(sm);
    cmp_valid = 1'b1;
    step(1);
    cmp_valid = 1'b0;
    step(2);
  endtask

  task automatic drain(input string req);
    int d0;
    int sm;
    d0 = done_cnt;
    for (int it = 0; it < 200; it++) begin
      sm = -1;
      for (int i = 0; i < NSM; i++) if (sm < 0 && m_cnt[i] > 0) sm = i;
      if (sm < 0) break;
      if (model_total() == 1 && exp_blk == cur_blocks)
        chk(done_cnt == d0, req, "no done before last completion", done_cnt, d0);
      complete(sm);
    end
    step(4);
    chk(done_cnt == d0 + 1, req, "done pulse after drain", done_cnt, d0 + 1);
    chk(launch_ready == 1'b1, "R9", "ready after done", int'(launch_ready), 1);
  endtask

  task automatic refused(input int b, input int t, input int r, input int s,
                         input bit ext, input string req);
    int e0, a0;
    e0 = err_cnt; a0 = asg_cnt;
    launch(b, t, r, s, ext);
    step(3);
    chk(err_cnt == e0 + 1, req, "launch_err pulse", err_cnt, e0 + 1);
    chk(asg_cnt == a0 && !asg_valid, req, "no assignment on refusal", asg_cnt, a0);
    chk(launch_ready == 1'b1, req, "ready after refusal", int'(launch_ready), 1);
  endtask

  initial begin
    #1_600_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a0, e0, d0;
    int sv_sm, sv_blk;
    for (int i = 0; i < NSM; i++) begin m_cnt[i] = 0; m_regs[i] = 0; m_smem[i] = 0; end
    step(4);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk(launch_ready == 1'b1, "R10", "launch_ready", int'(launch_ready), 1);
    chk(asg_valid == 1'b0, "R10", "asg_valid", int'(asg_valid), 0);
    chk(launch_err == 1'b0 && launch_done == 1'b0, "R10", "err/done", int'(launch_err), 0);

    // R3 thread limits per mode
    refused(4, 513, 1, 1, 1'b0, "R3");
    refused(4, 1025, 1, 1, 1'b1, "R3");
    // R4 per-block resources above one slot
    refused(4, 32, RTOT + 1, 1, 1'b0, "R4");
    refused(4, 32, 1, STOT + 1, 1'b0, "R4");

    // R1 block cap: tiny blocks fill every slot to MRES
    a0 = asg_cnt; d0 = done_cnt;
    launch(40, 512, 1, 1, 1'b0);
    step(60);
    chk(asg_cnt - a0 == NSM * MRES, "R1", "blocks resident at cap", asg_cnt - a0, NSM * MRES);
    chk(done_cnt == d0, "R8", "no done while resident", done_cnt, d0);
    chk(launch_ready == 1'b0, "R9", "ready low in launch", int'(launch_ready), 0);
    // R9 request during a launch is not taken
    e0 = err_cnt;
    launch(1, 2000, 1, 1, 1'b0);
    step(2);
    chk(err_cnt == e0, "R9", "busy request ignored", err_cnt, e0);
    // R7 a completion lets one waiting block in
    complete(2);
    step(2);
    chk(asg_cnt - a0 == NSM * MRES + 1, "R7", "block placed after completion",
        asg_cnt - a0, NSM * MRES + 1);
    drain("R8");
    chk(asg_cnt - a0 == 40, "R5", "all blocks issued", asg_cnt - a0, 40);

    // R2 register-bound residency: two per slot
    a0 = asg_cnt;
    launch(10, 256, 30, 10, 1'b0);
    step(20);
    chk(asg_cnt - a0 == 8, "R2", "register-bound residency", asg_cnt - a0, 8);
    drain("R8");
    // R2 shared-memory-bound residency: one per slot
    a0 = asg_cnt;
    launch(6, 64, 1, 40, 1'b0);
    step(20);
    chk(asg_cnt - a0 == 4, "R2", "smem-bound residency", asg_cnt - a0, 4);
    drain("R8");

    // R3 accepted at the extended limit
    a0 = asg_cnt; e0 = err_cnt;
    launch(1, 1024, 1, 1, 1'b1);
    step(4);
    chk(err_cnt == e0 && asg_cnt == a0 + 1, "R3", "1024 threads accepted", asg_cnt - a0, 1);
    drain("R8");

    // R6 held assignment under back-pressure
    asg_ready = 1'b0;
    launch(2, 32, 1, 1, 1'b0);
    step(2);
    sv_sm = int'(asg_sm); sv_blk = int'(asg_block);
    chk(asg_valid == 1'b1, "R6", "offer pending", int'(asg_valid), 1);
    step(3);
    chk(asg_valid == 1'b1 && int'(asg_sm) == sv_sm, "R6", "slot held", int'(asg_sm), sv_sm);
    chk(int'(asg_block) == sv_blk, "R6", "block held", int'(asg_block), sv_blk);
    asg_ready = 1'b1;
    step(4);
    drain("R8");

    // R7 completion on an empty slot is ignored
    d0 = done_cnt;
    launch(1, 32, RTOT, STOT, 1'b0);
    step(4);
    sv_sm = m_last;
    complete((sv_sm + 1) % NSM);
    step(3);
    chk(done_cnt == d0, "R7", "empty-slot completion ignored", done_cnt, d0);
    chk(m_cnt[sv_sm] == 1 && launch_ready == 1'b0, "R7", "launch still open",
        int'(launch_ready), 0);
    drain("R8");

    // R8 zero-block launch
    a0 = asg_cnt; d0 = done_cnt;
    launch(0, 32, 1, 1, 1'b0);
    step(3);
    chk(done_cnt == d0 + 1, "R8", "zero-block done", done_cnt, d0 + 1);
    chk(asg_cnt == a0, "R8", "zero-block no assignment", asg_cnt, a0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule